// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block holds a bank of general-purpose registers for a processor datapath: 32 entries of 32 bits by default. Two read ports work side by side. Each takes a register number and presents that entry's contents on its own data output through a multiplexer, with no clock in the path. Because the read side is purely combinational, an operand fetch settles within the same cycle that the register numbers arrive.

There is one write port. It takes a register number, a data word and a dedicated write line. A decoder turns the register number into one enable per entry. The addressed entry captures the data on the falling edge of the write line, so the data and register number must be steady around that edge. The write port does not forward to the read ports: a read of the entry being written returns the old contents until the falling edge and the new contents after it.

An active-high reset is sampled on the same falling edge and clears every entry. When reset and a write arrive together, reset wins.

Top module: `rf2r1w`

## Requirements
- R1: A falling edge of `wr_line` while `rst` is 1 sets every register to zero, and both read ports then return 0 for every register number.
- R2: A falling edge of `wr_line` while `rst` is 0 stores `wr_data` into the register numbered `wr_sel`.
- R3: A write changes only the register numbered `wr_sel`. Every other register keeps its value.
- R4: `rd_data_a` shows the register numbered `rd_sel_a` as soon as `rd_sel_a` changes, with no edge on `wr_line` needed.
- R5: `rd_data_b` shows the register numbered `rd_sel_b` independently of port A. When both ports select the same register, both outputs are equal.
- R6: While `wr_line` is high, a read of the register being written still returns the old value. The new value appears only after the falling edge.
- R7: A rising edge of `wr_line` stores nothing.
- R8: If `rst` is 1 at a falling edge, that edge stores nothing: the register numbered `wr_sel` is cleared like all the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_line | input | 1 | Write strobe; a write or reset is committed on its falling edge |
| rst | input | 1 | Active-high reset, sampled on the falling edge of `wr_line` |
| wr_sel | input | 5 | Number of the register to write |
| wr_data | input | 32 | Data to write |
| rd_sel_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Contents of the register selected by `rd_sel_a` |
| rd_sel_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Contents of the register selected by `rd_sel_b` |

## Verification
The read outputs have no register in their path. Each is due one time unit after its register number changes, and the bench samples it there. A write becomes visible one time unit after the falling edge of `wr_line`. The bench compares both ports against its own model at that point, and for R6 it also samples while the line is still high, before the falling edge. Write data and register numbers change only while `wr_line` is low and half a period away from the falling edge, so no check depends on the order of events at that edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_DEPTH = 32;
  localparam int unsigned RF_WIDTH = 32;
endpackage

// File: rtl/rf_wr_dec.sv
module rf_wr_dec #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned SEL_W    = $clog2(NUM_REGS)
) (
  input  logic [SEL_W-1:0]    sel,
  output logic [NUM_REGS-1:0] en
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign en[g] = (sel == SEL_W'(g));
  end
endmodule

// File: rtl/rf_word.sv
module rf_word #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_line,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(negedge wr_line) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  a_r1_word_cleared: assert property (@(negedge wr_line)
    $past(rst) |-> q == '0);

  a_r2_word_capture: assert property (@(negedge wr_line) disable iff (rst)
    (!$past(rst) && $past(en)) |-> q == $past(d));

  a_r3_word_hold: assert property (@(negedge wr_line) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> q == $past(q));
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned SEL_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [SEL_W-1:0]                sel,
  output logic [DATA_W-1:0]               data
);
  always_comb data = regs[sel];
endmodule

// File: rtl/rf2r1w.sv
module rf2r1w
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = RF_DEPTH,
  parameter int unsigned DATA_W   = RF_WIDTH,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              wr_line,
  input  logic              rst,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [SEL_W-1:0]  rd_sel_b,
  output logic [DATA_W-1:0] rd_data_b
);
  logic [NUM_REGS-1:0]             wr_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank;

  rf_wr_dec #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_dec (
    .sel (wr_sel),
    .en  (wr_en)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    rf_word #(.DATA_W(DATA_W)) u_word (
      .wr_line (wr_line),
      .rst     (rst),
      .en      (wr_en[g]),
      .d       (wr_data),
      .q       (bank[g])
    );
  end

  rf_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_mux_a (
    .regs (bank),
    .sel  (rd_sel_a),
    .data (rd_data_a)
  );

  rf_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_mux_b (
    .regs (bank),
    .sel  (rd_sel_b),
    .data (rd_data_b)
  );

  // R5: the two read multiplexers agree when both select the same entry
  a_r5_ports_agree: assert property (@(negedge wr_line) disable iff (rst)
    (rd_sel_a == rd_sel_b) |-> rd_data_a == rd_data_b);

  // R3: an entry that the previous edge did not address keeps its value at port A
  a_r3_port_a_untouched: assert property (@(negedge wr_line) disable iff (rst)
    (!$past(rst) && $past(rd_sel_a) == rd_sel_a && $past(wr_sel) != rd_sel_a)
      |-> rd_data_a == $past(rd_data_a));
endmodule

// File: tb/sim_rf2r1w.sv
module sim_rf2r1w;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        wr_line = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_sel_a = '0;
  logic [4:0]  rd_sel_b = '0;
  logic [31:0] rd_data_a;
  logic [31:0] rd_data_b;

  logic [31:0] model [NREG];
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1357_9BDF;

  rf2r1w u0 (
    .wr_line   (wr_line),
    .rst       (rst),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel_a  (rd_sel_a),
    .rd_data_a (rd_data_a),
    .rd_sel_b  (rd_sel_b),
    .rd_data_b (rd_data_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe();
    wr_line = 1'b1;
    #(CLK_PERIOD/2);
    wr_line = 1'b0;
    #(CLK_PERIOD/2);
  endtask

  task automatic do_write(input logic [4:0] sel, input logic [31:0] data);
    wr_sel = sel;
    wr_data = data;
    strobe();
    model[sel] = data;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NREG; i++) begin
      rd_sel_a = 5'(i);
      rd_sel_b = 5'(NREG - 1 - i);
      #1;
      check(req, rd_data_a, model[i]);
      check(req, rd_data_b, model[NREG - 1 - i]);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    // R1: reset clears every entry
    rst = 1'b1;
    wr_sel = 5'd7;
    wr_data = 32'hFFFF_FFFF;
    strobe();
    strobe();
    rst = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    #1;
    sweep("R1 reset value");

    // R2: fill every entry with an arithmetic pattern, check port A right after
    for (int i = 0; i < NREG; i++) begin
      do_write(5'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(i << 3));
      rd_sel_a = 5'(i);
      #1;
      check("R2 write then read", rd_data_a, model[i]);
    end
    // R3, R5: full sweep of both ports
    sweep("R3 R5 full sweep after fill");

    // R4: select changes alone move the output
    for (int i = 0; i < NREG; i++) begin
      rd_sel_a = 5'(NREG - 1 - i);
      #1;
      check("R4 combinational select A", rd_data_a, model[NREG - 1 - i]);
      rd_sel_b = 5'(i);
      rd_sel_a = 5'(i);
      #1;
      check("R5 same select B", rd_data_b, model[i]);
      check("R5 same select A", rd_data_a, model[i]);
    end

    // R2, R3: pseudo-random writes, every entry compared after each
    for (int n = 0; n < 150; n++) begin
      step_lfsr();
      do_write(lfsr[4:0], lfsr ^ 32'h5A5A_0F0F);
      sweep("R3 random write sweep");
    end

    // R6, R7: no forwarding while the line is high
    rd_sel_a = 5'd9;
    rd_sel_b = 5'd9;
    wr_sel = 5'd9;
    wr_data = ~model[9];
    #1;
    wr_line = 1'b1;
    #1;
    check("R7 rising edge stores nothing", rd_data_a, model[9]);
    check("R6 old value before fall", rd_data_b, model[9]);
    #(CLK_PERIOD/2 - 1);
    wr_line = 1'b0;
    model[9] = ~model[9];
    #1;
    check("R6 new value after fall A", rd_data_a, model[9]);
    check("R6 new value after fall B", rd_data_b, model[9]);
    #(CLK_PERIOD/2 - 1);

    // R8: reset beats a write on the same edge
    rst = 1'b1;
    wr_sel = 5'd5;
    wr_data = 32'hDEAD_BEEF;
    strobe();
    rst = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    rd_sel_a = 5'd5;
    #1;
    check("R8 reset wins over write", rd_data_a, 32'h0);
    sweep("R1 R8 sweep after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule